// File: doc/BRIEF.md
# Per-Port Output Rate Shaper

This block limits how fast one output port may start new packets. Every packet start and every 8-byte data word sent charges a cost into a credit accumulator, and a fixed amount drains out of it each clock cycle. While the accumulated cost stays at or under a programmed burst ceiling, the port is reported as allowed. Once the ceiling is exceeded, the scheduler holds off new packets until enough cost has drained away.

Three programmed values set the behaviour. The first is a per-packet cost in coarse units of 256 fine tokens, meant to cover wire overhead that the data words never show: 12 bytes of gap, 8 bytes of preamble and 4 bytes of CRC. The second is a per-word cost in single fine tokens. The third is the burst ceiling, also in coarse units. A per-word cost of zero gives a packets-per-second limiter. A non-zero per-word cost gives a bits-per-second limiter. Software derives all three values from the clock frequency and the target rate.

The limit applies only at packet start. A packet that has already begun keeps sending its words, and every one of those words is still charged.

Top module: `port_rate_shaper`

## Requirements
- R1: While reset is asserted and after it, the accumulator is empty and all three programmed values are zero, so `port_allowed` is high.
- R2: Each cycle with `pkt_start` high adds the per-packet cost times 256 fine tokens to the accumulator. The new value is visible at the next clock edge.
- R3: Each cycle with `word_valid` high adds the per-word cost in fine tokens. With a per-word cost of zero, word strobes never change `port_allowed`.
- R4: Each clock cycle the accumulator first drains by 16 fine tokens and then receives that cycle's charges. The drain stops at zero and the accumulator never goes below zero.
- R5: While enabled, `port_allowed` is high exactly when the accumulator is less than or equal to the burst ceiling times 256. Equality counts as allowed.
- R6: Adding charges saturates the accumulator at 2^ACC_W-1 instead of wrapping. With default widths and a ceiling of 4095, `port_allowed` returns 16 idle cycles after saturation.
- R7: Charges are accepted whether `port_allowed` is high or low, so words of a packet in progress keep adding cost while the port is held off.
- R8: A cycle with `cfg_we` high loads all three programmed values and clears the accumulator. Any charges presented in that same cycle are dropped.
- R9: While `enable` is low, `port_allowed` is high, charges are ignored and the accumulator is held at zero. After re-enabling, the port starts from an empty accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Shaping enable; when low the port is always allowed |
| cfg_we | input | 1 | Load the three programmed values and clear the accumulator |
| cfg_pkt_cost | input | PKT_W | Per-packet cost in units of 256 fine tokens |
| cfg_word_cost | input | WORD_W | Per-word cost in fine tokens |
| cfg_burst | input | LIM_W | Burst ceiling in units of 256 fine tokens |
| pkt_start | input | 1 | One-cycle strobe when a packet begins |
| word_valid | input | 1 | One-cycle strobe for each 8-byte data word sent |
| port_allowed | output | 1 | High when the scheduler may start a new packet |

## Verification
The hardest case to reach from the ports is saturation at the accumulator's top value. A wrapping adder and a saturating adder look identical until the sum crosses 2^ACC_W. The stimulus programs the largest packet and word costs and the largest ceiling, then strobes a packet and a word every cycle for 20 cycles, which pushes well past the top. It then counts idle cycles until `port_allowed` returns: this happens after exactly 16 cycles when the accumulator saturated, and at once when it wrapped. The zero floor is exposed in a similar way. A small charge is drained past zero, and a second small charge must again hold the port off for exactly one cycle, which a wrapped negative value would not.

// File: rtl/shaper_pkg.sv
package shaper_pkg;
  // one coarse unit is 2**COARSE_SHIFT fine tokens
  localparam int unsigned COARSE_SHIFT = 8;
  // fine tokens removed from the accumulator each clock
  localparam int unsigned DRAIN_DEFAULT = 16;
endpackage

// File: rtl/shaper_cfg_regs.sv
module shaper_cfg_regs #(
  parameter int unsigned PKT_W  = 8,
  parameter int unsigned WORD_W = 12,
  parameter int unsigned LIM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PKT_W-1:0]  pkt_cost_in,
  input  logic [WORD_W-1:0] word_cost_in,
  input  logic [LIM_W-1:0]  burst_in,
  output logic [PKT_W-1:0]  pkt_cost_q,
  output logic [WORD_W-1:0] word_cost_q,
  output logic [LIM_W-1:0]  burst_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_cost_q  <= '0;
      word_cost_q <= '0;
      burst_q     <= '0;
    end else if (load) begin
      pkt_cost_q  <= pkt_cost_in;
      word_cost_q <= word_cost_in;
      burst_q     <= burst_in;
    end
  end
endmodule

// File: rtl/shaper_charge.sv
module shaper_charge
  import shaper_pkg::*;
#(
  parameter int unsigned PKT_W  = 8,
  parameter int unsigned WORD_W = 12,
  localparam int unsigned PKT_FINE_W = PKT_W + COARSE_SHIFT,
  localparam int unsigned CHG_W = ((PKT_FINE_W > WORD_W) ? PKT_FINE_W : WORD_W) + 1
) (
  input  logic              pkt_start,
  input  logic              word_valid,
  input  logic [PKT_W-1:0]  pkt_cost,
  input  logic [WORD_W-1:0] word_cost,
  output logic [CHG_W-1:0]  charge
);
  function automatic logic [CHG_W-1:0] coarse_to_fine(input logic [PKT_W-1:0] c);
    logic [CHG_W-1:0] ext;
    ext = CHG_W'(c);
    return ext << COARSE_SHIFT;
  endfunction

  logic [CHG_W-1:0] pkt_part;
  logic [CHG_W-1:0] word_part;

  always_comb begin
    pkt_part  = pkt_start  ? coarse_to_fine(pkt_cost) : '0;
    word_part = word_valid ? CHG_W'(word_cost)       : '0;
    charge    = pkt_part + word_part;
  end
endmodule

// File: rtl/shaper_bucket.sv
module shaper_bucket #(
  parameter int unsigned ACC_W = 20,
  parameter int unsigned CHG_W = 17,
  parameter int unsigned DRAIN = 16,
  localparam int unsigned SUM_W = ((ACC_W > CHG_W) ? ACC_W : CHG_W) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CHG_W-1:0] charge,
  output logic [ACC_W-1:0] drained,
  output logic [ACC_W-1:0] acc_q
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  function automatic logic [ACC_W-1:0] drain_floor(input logic [ACC_W-1:0] a);
    return (a > ACC_W'(DRAIN)) ? a - ACC_W'(DRAIN) : '0;
  endfunction

  function automatic logic [ACC_W-1:0] add_sat(input logic [ACC_W-1:0] a,
                                               input logic [CHG_W-1:0] c);
    logic [SUM_W-1:0] s;
    s = SUM_W'(a) + SUM_W'(c);
    return (s > SUM_W'(ACC_MAX)) ? ACC_MAX : s[ACC_W-1:0];
  endfunction

  assign drained = drain_floor(acc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clear) acc_q <= '0;
    else            acc_q <= add_sat(drained, charge);
  end
endmodule

// File: rtl/port_rate_shaper.sv
module port_rate_shaper
  import shaper_pkg::*;
#(
  parameter int unsigned PKT_W  = 8,
  parameter int unsigned WORD_W = 12,
  parameter int unsigned LIM_W  = 12,
  parameter int unsigned ACC_W  = 20,
  parameter int unsigned DRAIN  = DRAIN_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_we,
  input  logic [PKT_W-1:0]  cfg_pkt_cost,
  input  logic [WORD_W-1:0] cfg_word_cost,
  input  logic [LIM_W-1:0]  cfg_burst,
  input  logic              pkt_start,
  input  logic              word_valid,
  output logic              port_allowed
);
  localparam int unsigned PKT_FINE_W = PKT_W + COARSE_SHIFT;
  localparam int unsigned CHG_W = ((PKT_FINE_W > WORD_W) ? PKT_FINE_W : WORD_W) + 1;
  localparam int unsigned LIM_FINE_W = LIM_W + COARSE_SHIFT;
  localparam int unsigned CMP_W = (ACC_W > LIM_FINE_W) ? ACC_W : LIM_FINE_W;

  logic [PKT_W-1:0]  pkt_cost_q;
  logic [WORD_W-1:0] word_cost_q;
  logic [LIM_W-1:0]  burst_q;
  logic [CHG_W-1:0]  charge;
  logic [ACC_W-1:0]  drained;
  logic [ACC_W-1:0]  acc_q;
  logic              clear_acc;
  logic              under_limit;

  function automatic logic within_burst(input logic [ACC_W-1:0] a,
                                        input logic [LIM_W-1:0] b);
    logic [CMP_W-1:0] lim;
    lim = CMP_W'(b) << COARSE_SHIFT;
    return CMP_W'(a) <= lim;
  endfunction

  shaper_cfg_regs #(.PKT_W(PKT_W), .WORD_W(WORD_W), .LIM_W(LIM_W)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (cfg_we),
    .pkt_cost_in  (cfg_pkt_cost),
    .word_cost_in (cfg_word_cost),
    .burst_in     (cfg_burst),
    .pkt_cost_q   (pkt_cost_q),
    .word_cost_q  (word_cost_q),
    .burst_q      (burst_q)
  );

  shaper_charge #(.PKT_W(PKT_W), .WORD_W(WORD_W)) u_charge (
    .pkt_start  (pkt_start),
    .word_valid (word_valid),
    .pkt_cost   (pkt_cost_q),
    .word_cost  (word_cost_q),
    .charge     (charge)
  );

  assign clear_acc = cfg_we || !enable;

  shaper_bucket #(.ACC_W(ACC_W), .CHG_W(CHG_W), .DRAIN(DRAIN)) u_bucket (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear_acc),
    .charge  (charge),
    .drained (drained),
    .acc_q   (acc_q)
  );

  assign under_limit  = within_burst(acc_q, burst_q);
  assign port_allowed = !enable || under_limit;
endmodule

// File: rtl/shaper_checks.sv
module shaper_checks #(
  parameter int unsigned ACC_W = 20,
  parameter int unsigned DRAIN = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             cfg_we,
  input logic             pkt_start,
  input logic             word_valid,
  input logic             port_allowed,
  input logic [ACC_W-1:0] acc_q,
  input logic [ACC_W-1:0] drained
);
  assert_drain_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (drained <= acc_q) && ((acc_q - drained) <= ACC_W'(DRAIN)));

  assert_idle_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !cfg_we && !pkt_start && !word_valid) |=> (acc_q == $past(drained)));

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !cfg_we) |=> ((ACC_W+1)'(acc_q) + (ACC_W+1)'(DRAIN) >= (ACC_W+1)'($past(acc_q))));

  assert_cfg_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (acc_q == '0));

  assert_disabled_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> port_allowed);

  assert_disabled_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !cfg_we) |=> (acc_q == '0));

  assert_empty_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == '0) |-> port_allowed);
endmodule

bind port_rate_shaper shaper_checks #(.ACC_W(ACC_W), .DRAIN(DRAIN)) u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .cfg_we       (cfg_we),
  .pkt_start    (pkt_start),
  .word_valid   (word_valid),
  .port_allowed (port_allowed),
  .acc_q        (acc_q),
  .drained      (drained)
);

// File: tb/test_port_rate_shaper.sv
module test_port_rate_shaper;
  localparam int CLK_PERIOD = 10;
  localparam longint ACC_TOP = (64'd1 << 20) - 1;

  typedef struct {
    logic  exp;
    string req;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_pkt_cost = '0;
  logic [11:0] cfg_word_cost = '0;
  logic [11:0] cfg_burst = '0;
  logic        pkt_start = 1'b0;
  logic        word_valid = 1'b0;
  logic        port_allowed;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sb_item_t sb_q[$];

  longint m_acc = 0, m_pkt = 0, m_word = 0, m_burst = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_rate_shaper i_port_rate_shaper (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .cfg_we        (cfg_we),
    .cfg_pkt_cost  (cfg_pkt_cost),
    .cfg_word_cost (cfg_word_cost),
    .cfg_burst     (cfg_burst),
    .pkt_start     (pkt_start),
    .word_valid    (word_valid),
    .port_allowed  (port_allowed)
  );

  // driver: apply one cycle of stimulus, advance the reference, queue the expectation
  task automatic step(input logic en, input logic we, input logic ps, input logic wv,
                      input int pc, input int wc, input int bl, input string req);
    sb_item_t it;
    longint d;
    @(negedge clk);
    enable = en; cfg_we = we; pkt_start = ps; word_valid = wv;
    cfg_pkt_cost = 8'(pc); cfg_word_cost = 12'(wc); cfg_burst = 12'(bl);
    if (!rst_n) begin
      m_acc = 0; m_pkt = 0; m_word = 0; m_burst = 0;
    end else if (we) begin
      m_pkt = pc; m_word = wc; m_burst = bl; m_acc = 0;
    end else if (!en) begin
      m_acc = 0;
    end else begin
      d = (m_acc > 16) ? m_acc - 16 : 0;
      d = d + (ps ? m_pkt * 256 : 0) + (wv ? m_word : 0);
      m_acc = (d > ACC_TOP) ? ACC_TOP : d;
    end
    it.exp = !en || (m_acc <= m_burst * 256);
    it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic run(input logic ps, input logic wv, input string req);
    step(1'b1, 1'b0, ps, wv, int'(cfg_pkt_cost), int'(cfg_word_cost), int'(cfg_burst), req);
  endtask

  task automatic load(input int pc, input int wc, input int bl, input string req);
    step(1'b1, 1'b1, 1'b1, 1'b1, pc, wc, bl, req);
  endtask

  // monitor: compare after each active edge, well before the next drive
  always @(posedge clk) begin
    sb_item_t it;
    #2;
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      checks++;
      if (port_allowed !== it.exp) begin
        fails++;
        $display("FAIL %s: port_allowed=%b expected=%b at %0t", it.req, port_allowed, it.exp, $time);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state, enabled with zero ceiling, empty accumulator is allowed
    repeat (3) step(1'b1, 1'b0, 1'b1, 1'b1, 0, 0, 0, "R1");
    @(negedge clk); rst_n = 1'b1;
    run(1'b0, 1'b0, "R1");

    // R2: packets only, cost 3 coarse, ceiling 4 coarse
    load(3, 0, 4, "R8");
    run(1'b1, 1'b0, "R2");
    run(1'b1, 1'b0, "R2");
    repeat (40) run(1'b0, 1'b0, "R4");

    // R3: word cost only
    load(0, 100, 2, "R8");
    repeat (8) run(1'b0, 1'b1, "R3");
    repeat (40) run(1'b0, 1'b0, "R4");

    // R3: zero word cost never limits
    load(1, 0, 1, "R8");
    repeat (10) run(1'b0, 1'b1, "R3");

    // R7: words keep charging while held off
    load(2, 50, 2, "R8");
    run(1'b1, 1'b1, "R7");
    repeat (10) run(1'b0, 1'b1, "R7");
    repeat (60) run(1'b0, 1'b0, "R7");

    // R9: disable forces allowed and empties the accumulator
    load(4, 0, 1, "R8");
    run(1'b1, 1'b0, "R9");
    step(1'b0, 1'b0, 1'b1, 1'b1, 4, 0, 1, "R9");
    step(1'b0, 1'b0, 1'b1, 1'b0, 4, 0, 1, "R9");
    run(1'b0, 1'b0, "R9");

    // R8: configuration write clears a full accumulator, same-cycle charges dropped
    run(1'b1, 1'b0, "R8");
    load(4, 0, 1, "R8");
    run(1'b0, 1'b0, "R8");

    // R5: equality with the ceiling is allowed, one token over is not
    load(4, 17, 4, "R8");
    run(1'b1, 1'b0, "R5");
    run(1'b0, 1'b1, "R5");
    run(1'b0, 1'b0, "R5");

    // R4: drain stops at zero, ceiling zero
    load(0, 10, 0, "R8");
    run(1'b0, 1'b1, "R4");
    repeat (5) run(1'b0, 1'b0, "R4");
    run(1'b0, 1'b1, "R4");
    run(1'b0, 1'b0, "R4");

    // R6: saturation at the top, then exactly 16 idle cycles to reopen
    load(255, 4095, 4095, "R8");
    repeat (20) run(1'b1, 1'b1, "R6");
    repeat (20) run(1'b0, 1'b0, "R6");

    @(negedge clk);
    pkt_start = 1'b0; word_valid = 1'b0; cfg_we = 1'b0;
    repeat (2) @(posedge clk);
    #5;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule